// File: doc/BRIEF.md
# Four-Channel Prescaled Down-Counter Timer

This block holds four independent down-counters behind a small register bus. Each counter runs from a tick made by dividing the system clock in two steps. The first step is an 8-bit prescale setting, shared by channels 0 and 1 and by channels 2 and 3. The second step is a per-channel power-of-two divider. Software programs a count buffer and a compare buffer. It pulses a manual-update control bit to copy both into the live counter and the live compare register. In a later write it sets the run bit, and optionally auto-reload.

Each channel drives a pulse-width output. The output is high while the live count exceeds the live compare value, and an invert bit flips it. Each counter raises a sticky pending flag when it reloads, or when a one-shot counter expires. A single interrupt line combines the pending flags with per-channel enables. The bus is a single-cycle select/write strobe with combinational read data. It has no back-pressure: every access completes in the cycle it is presented.

Top module: `quad_tick_timer`

## Requirements
- R1: Register offsets: prescale config 0x00, divider config 0x04, control 0x08, status 0x44. Channel c has its count buffer at 0x0C+0x0C·c, its compare buffer at 0x10+0x0C·c and its read-only live count at 0x14+0x0C·c. After reset every register and every live count reads zero.
- R2: Channels 0 and 1 take their prescale value P from config bits [7:0], and channels 2 and 3 from bits [15:8]. Channel c takes its divider select m from config bits [4c+3:4c]. The tick period is (P+1)·2^m clocks.
- R3: A divider select above 4 behaves exactly as 4.
- R4: Channel 0's control group starts at bit 0, and channel c>0's group starts at bit 4c+4. Within a group, bit 0 is run, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. A write affects only the channel whose group it changes.
- R5: While manual update is set, the live count and live compare are loaded from the buffers on every clock, and counting is suspended.
- R6: While run is set, the live count drops by one per tick. The divider restarts when run goes high, so the first decrement comes a full tick period after the write that sets run.
- R7: With run clear, the live count holds its value.
- R8: With auto-reload set, a tick at count zero reloads the count buffer, so a buffer value of N−1 gives a period of N ticks. That tick sets the channel's pending flag.
- R9: With auto-reload clear, a tick at count zero sets pending once. The count then stays at zero and raises no further pending until the next manual update.
- R10: Status bit c is channel c's interrupt enable, which reads and writes plainly. Status bit c+5 is its pending flag: writing 1 clears it and writing 0 leaves it. A hardware set wins over a clear in the same cycle.
- R11: The interrupt output is high exactly when some channel has both its pending flag and its enable set.
- R12: Each pulse output is (live count > live compare) XOR invert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Combined interrupt |
| pwm_out | output | 4 | Per-channel pulse outputs |

## Verification
The bench uses the default parameters: four 32-bit channels, 8-bit prescale fields and a divider cap of 4. This makes every register offset and control-group position reachable. Prescale values of 0 and 1 with small count buffers make reload periods, one-shot expiry and the first-tick delay visible within a few clocks. The clamped divider select (7, giving 16) stays short enough to count out exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW         = 32;
  localparam int PRE_STRIDE = 8;
  localparam int SEL_STRIDE = 4;
  localparam int CH_BASE    = 'h0C;
  localparam int CH_STRIDE  = 'h0C;
  localparam int OFS_CFG0   = 'h00;
  localparam int OFS_CFG1   = 'h04;
  localparam int OFS_CTRL   = 'h08;
  localparam int OFS_STAT   = 'h44;
  localparam int PEND_POS   = 5;

  typedef struct packed {
    logic autorl;
    logic inv;
    logic upd;
    logic run;
  } ch_ctrl_t;

  function automatic int ctrl_pos(input int c);
    return (c == 0) ? 0 : 4 * c + 4;
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PRE_W   = 8,
  parameter int SEL_W   = 4,
  parameter int DIV_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_lim,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int DIV_CW = (DIV_MAX > 0) ? DIV_MAX : 1;

  logic [PRE_W-1:0]  pre_cnt;
  logic [DIV_CW-1:0] div_cnt;
  logic [DIV_CW-1:0] div_lim;
  logic [SEL_W-1:0]  eff_sel;
  logic              pre_hit, div_hit;

  assign eff_sel = (div_sel > SEL_W'(DIV_MAX)) ? SEL_W'(DIV_MAX) : div_sel;

  always_comb begin
    for (int i = 0; i < DIV_CW; i++) div_lim[i] = (SEL_W'(i) < eff_sel);
  end

  assign pre_hit = (pre_cnt == pre_lim);
  assign div_hit = (div_cnt == div_lim);
  assign tick    = run && pre_hit && div_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_hit) begin
      pre_cnt <= '0;
      div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R6: no tick in the first clock of a run interval (full period from start)
  a_r6_full_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (pre_cnt == '0 && div_cnt == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_pkg::ch_ctrl_t ctrl,
  input  logic              tick,
  input  logic [CW-1:0]     cnt_buf,
  input  logic [CW-1:0]     cmp_buf,
  output logic [CW-1:0]     cnt_q,
  output logic              pwm,
  output logic              evt
);
  logic [CW-1:0] cmp_q;
  logic          spent;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);
  assign evt     = !ctrl.upd && ctrl.run && tick && at_zero && (ctrl.autorl || !spent);
  assign pwm     = (cnt_q > cmp_q) ^ ctrl.inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      spent <= 1'b0;
    end else if (ctrl.upd) begin
      cnt_q <= cnt_buf;
      cmp_q <= cmp_buf;
      spent <= 1'b0;
    end else if (ctrl.run && tick) begin
      if (!at_zero)         cnt_q <= cnt_q - 1'b1;
      else if (ctrl.autorl) cnt_q <= cnt_buf;
      else                  spent <= 1'b1;
    end
  end

  a_r5_update_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.upd |=> (cnt_q == $past(cnt_buf)));
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && tick && !ctrl.upd && !at_zero) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !ctrl.upd) |=> $stable(cnt_q));
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && tick && !ctrl.upd && at_zero && ctrl.autorl) |=> (cnt_q == $past(cnt_buf)));
  a_r9_oneshot_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !ctrl.autorl && !ctrl.upd) |=> (cnt_q == '0));
endmodule

// File: rtl/quad_tick_timer.sv
module quad_tick_timer #(
  parameter int NUM_CH  = 4,
  parameter int CW      = 32,
  parameter int PRE_W   = 8,
  parameter int SEL_W   = 4,
  parameter int DIV_MAX = 4,
  parameter int AW      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [tmr_pkg::DW-1:0] bus_wdata,
  output logic [tmr_pkg::DW-1:0] bus_rdata,
  output logic                   irq,
  output logic [NUM_CH-1:0]      pwm_out
);
  import tmr_pkg::*;

  logic [DW-1:0] cfg0_q, cfg1_q, ctrl_q;
  logic [CW-1:0] cnt_buf_q [NUM_CH];
  logic [CW-1:0] cmp_buf_q [NUM_CH];
  logic [CW-1:0] live_cnt  [NUM_CH];
  logic [NUM_CH-1:0] en_q, pend_q, ev;
  logic          wr_go, w_stat;

  assign wr_go  = bus_sel && bus_wr;
  assign w_stat = wr_go && (bus_addr == AW'(OFS_STAT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
      ctrl_q <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        cnt_buf_q[c] <= '0;
        cmp_buf_q[c] <= '0;
      end
    end else if (wr_go) begin
      if (bus_addr == AW'(OFS_CFG0)) cfg0_q <= bus_wdata;
      if (bus_addr == AW'(OFS_CFG1)) cfg1_q <= bus_wdata;
      if (bus_addr == AW'(OFS_CTRL)) ctrl_q <= bus_wdata;
      for (int c = 0; c < NUM_CH; c++) begin
        if (bus_addr == AW'(CH_BASE + CH_STRIDE * c))     cnt_buf_q[c] <= bus_wdata[CW-1:0];
        if (bus_addr == AW'(CH_BASE + CH_STRIDE * c + 4)) cmp_buf_q[c] <= bus_wdata[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (w_stat) en_q[c] <= bus_wdata[c];
        pend_q[c] <= ev[c] | (pend_q[c] & ~(w_stat & bus_wdata[PEND_POS + c]));
      end
    end
  end

  assign irq = |(pend_q & en_q);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int CB = ctrl_pos(c);
    ch_ctrl_t   cc;
    logic       tk;
    assign cc = ctrl_q[CB +: 4];

    tmr_tick_gen #(.PRE_W(PRE_W), .SEL_W(SEL_W), .DIV_MAX(DIV_MAX)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (cc.run && !cc.upd),
      .pre_lim (cfg0_q[(c / 2) * PRE_STRIDE +: PRE_W]),
      .div_sel (cfg1_q[c * SEL_STRIDE +: SEL_W]),
      .tick    (tk)
    );

    tmr_channel #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl    (cc),
      .tick    (tk),
      .cnt_buf (cnt_buf_q[c]),
      .cmp_buf (cmp_buf_q[c]),
      .cnt_q   (live_cnt[c]),
      .pwm     (pwm_out[c]),
      .evt     (ev[c])
    );

    a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (w_stat && bus_wdata[PEND_POS + c] && !ev[c]) |=> !pend_q[c]);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[c] && !(w_stat && bus_wdata[PEND_POS + c])) |=> pend_q[c]);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ev[c] |=> pend_q[c]);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_CFG0))      bus_rdata = cfg0_q;
    else if (bus_addr == AW'(OFS_CFG1)) bus_rdata = cfg1_q;
    else if (bus_addr == AW'(OFS_CTRL)) bus_rdata = ctrl_q;
    else if (bus_addr == AW'(OFS_STAT)) begin
      for (int c = 0; c < NUM_CH; c++) begin
        bus_rdata[c]            = en_q[c];
        bus_rdata[PEND_POS + c] = pend_q[c];
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (bus_addr == AW'(CH_BASE + CH_STRIDE * c))     bus_rdata = DW'(cnt_buf_q[c]);
        if (bus_addr == AW'(CH_BASE + CH_STRIDE * c + 4)) bus_rdata = DW'(cmp_buf_q[c]);
        if (bus_addr == AW'(CH_BASE + CH_STRIDE * c + 8)) bus_rdata = DW'(live_cnt[c]);
      end
    end
  end
endmodule

// File: tb/quad_tick_timer_bench.sv
module quad_tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [3:0]  pwm_out;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  quad_tick_timer u_quad_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .pwm_out(pwm_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    rchk("R1 reset cfg0", 8'h00, 0);
    rchk("R1 reset cfg1", 8'h04, 0);
    rchk("R1 reset ctrl", 8'h08, 0);
    rchk("R1 reset stat", 8'h44, 0);
    rchk("R1 reset live0", 8'h14, 0);
    chk("R11 reset irq", {31'b0, irq}, 0);
    chk("R12 reset pwm", {28'b0, pwm_out}, 0);
  endtask

  task automatic t_map;
    wr(8'h24, 32'h55);
    wr(8'h34, 32'hAA);
    rchk("R1 ch2 count buf", 8'h24, 32'h55);
    rchk("R1 ch3 compare buf", 8'h34, 32'hAA);
    rchk("R1 ch1 count buf untouched", 8'h18, 0);
    rchk("R1 ch3 live untouched", 8'h38, 0);
  endtask

  task automatic t_update;
    wr(8'h0C, 5); wr(8'h10, 2);
    wr(8'h00, 32'h1); wr(8'h04, 32'h1);
    wr(8'h08, 32'h2);
    idle(3);
    rchk("R5 update loads live0 and holds", 8'h14, 5);
  endtask

  task automatic t_count;
    wr(8'h08, 32'h9);
    idle(3);
    rchk("R6 first tick after full period", 8'h14, 5);
    idle(1);
    rchk("R2 R6 first decrement at 4 clocks", 8'h14, 4);
    idle(4);
    rchk("R2 R6 second decrement", 8'h14, 3);
  endtask

  task automatic t_stop;
    wr(8'h08, 32'h8);
    idle(20);
    rchk("R7 stopped count holds", 8'h14, 3);
  endtask

  task automatic t_pwm;
    chk("R12 pwm0 high count>cmp", {31'b0, pwm_out[0]}, 1);
    chk("R12 pwm1 low equal", {31'b0, pwm_out[1]}, 0);
    wr(8'h08, 32'hC);
    chk("R12 pwm0 inverted", {31'b0, pwm_out[0]}, 0);
    wr(8'h08, 32'h8);
  endtask

  task automatic t_reload;
    wr(8'h18, 2); wr(8'h1C, 0);
    wr(8'h08, 32'h208);
    idle(1);
    rchk("R4 ch1 update bit 9", 8'h20, 2);
    wr(8'h08, 32'h908);
    idle(5);
    rchk("R8 ch1 at zero", 8'h20, 0);
    rchk("R8 no pending before reload", 8'h44, 0);
    idle(1);
    rchk("R8 reload after N ticks", 8'h20, 2);
    rchk("R8 pending on reload", 8'h44, 32'h40);
    wr(8'h08, 32'h808);
    rchk("R4 ch0 unaffected", 8'h14, 3);
  endtask

  task automatic t_status;
    wr(8'h44, 32'h2);
    rchk("R10 write 0 keeps pending", 8'h44, 32'h42);
    chk("R11 irq on enable+pending", {31'b0, irq}, 1);
    wr(8'h44, 32'h42);
    rchk("R10 write 1 clears pending", 8'h44, 32'h2);
    chk("R11 irq drops", {31'b0, irq}, 0);
    wr(8'h44, 32'h0);
  endtask

  task automatic t_oneshot;
    wr(8'h00, 32'h1); wr(8'h04, 32'h1);
    wr(8'h24, 1); wr(8'h28, 0);
    wr(8'h08, 32'h2808);
    idle(1);
    rchk("R4 ch2 update bit 13", 8'h2C, 1);
    wr(8'h08, 32'h1808);
    idle(2);
    rchk("R9 one-shot at zero", 8'h2C, 0);
    rchk("R9 one-shot pending", 8'h44, 32'h80);
    wr(8'h44, 32'h80);
    idle(6);
    rchk("R9 no repeat pending", 8'h44, 0);
    rchk("R9 stays zero", 8'h2C, 0);
  endtask

  task automatic t_clamp;
    wr(8'h04, 32'h7001);
    wr(8'h30, 10);
    wr(8'h08, 32'h21808);
    idle(1);
    rchk("R4 ch3 update bit 17", 8'h38, 10);
    wr(8'h08, 32'h11808);
    idle(15);
    rchk("R3 clamp no tick before 16", 8'h38, 10);
    idle(1);
    rchk("R3 clamped divide by 16", 8'h38, 9);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_map();
    t_update();
    t_count();
    t_stop();
    t_pwm();
    t_reload();
    t_status();
    t_oneshot();
    t_clamp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule